// File: doc/BRIEF.md
# Four-Vector Interrupt Controller

This block gathers eleven interrupt sources into one vectored request towards a small CPU core. Three sources have a vector of their own: the external interrupt pin, the timer-0 overflow and the external timer-clock edge. The other eight share a fourth vector: port change, timer-1/2/3 overflow, serial transmit-empty, serial receive-full and two capture events. Every source has a flag and an enable bit. The eight shared sources also feed a summary bit, and that summary has its own enable. A global disable bit gates every request to the core.

The request to the core uses a valid/ready handshake. `irq_req` is the valid and `irq_vec` is its payload. `irq_ack` is the ready. An interrupt is taken in the cycle where both are high. The core may hold `irq_ack` low for as long as it likes, and the request stays up while anything enabled is still pending. Until the request is taken, a higher-priority source that becomes pending may replace the vector. At the handshake, `stk_push` pulses, the global disable bit sets, and a dedicated source has its flag cleared. A shared-vector entry clears nothing, so software must clear the peripheral flags. A return pulse on `irq_ret` drives `stk_pop` and clears the global disable bit. `wake` reports any enabled pending source and ignores the global disable bit.

Software reaches the state through a four-word CSR port. Reads are combinational.
- Address 0 holds the dedicated flags in bits 2:0, the peripheral summary in bit 3 (read-only), the dedicated enables in bits 6:4 and the summary enable in bit 7.
- Address 1 holds the eight peripheral flags.
- Address 2 holds the eight peripheral enables.
- Address 3 holds the global disable in bit 0.

Bit order in `src_evt` and in each group runs as listed above: pin, timer-0, clock edge, then port change, timer-1, timer-2, timer-3, transmit, receive, capture-1, capture-2.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset all flags and enables read 0, the global disable bit reads 1, and `irq_req` and `wake` are low.
- R2: A one-cycle pulse on an `src_evt` bit sets its flag on the next edge, whatever the state of its enable and of the global disable bit.
- R3: `irq_req` is high exactly when the global disable bit is 0 and at least one enabled source is pending. A shared source counts as pending only when its own enable and the summary enable are both set.
- R4: `irq_vec` selects by fixed priority: pin (VEC_PIN, default 0x0008), then timer-0 (VEC_TMR0, 0x0010), then clock edge (VEC_TCLK, 0x0018), then peripheral (VEC_PERI, 0x0020).
- R5: In a cycle where `irq_req` and `irq_ack` are both high, `stk_push` is high, and from the next cycle the global disable bit reads 1 and `irq_req` is low.
- R6: Taking a dedicated vector clears that source's flag. Taking the peripheral vector leaves all peripheral flags unchanged.
- R7: A pulse on `irq_ret` drives `stk_pop` high in that cycle and clears the global disable bit at the next edge.
- R8: A CSR write of 1 to a flag bit sets it and a write of 0 clears it. An event on the same source in the same cycle wins over the clear.
- R9: `wake` is high whenever any enabled source is pending, also while the global disable bit is set.
- R10: Bit 3 of address 0 reads the OR of the peripheral flags ANDed with their enables, regardless of the summary enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | 11 | Source event pulses, one bit per source |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 2 | CSR word address |
| csr_wdata | input | 8 | CSR write data |
| csr_rdata | output | 8 | CSR read data for csr_addr |
| irq_req | output | 1 | Interrupt request (valid) |
| irq_ack | input | 1 | Core accepts the request (ready) |
| irq_vec | output | 16 | Vector address of the winning source |
| irq_ret | input | 1 | Return-from-interrupt pulse |
| stk_push | output | 1 | Push return address this cycle |
| stk_pop | output | 1 | Pop return address this cycle |
| wake | output | 1 | Any enabled source pending |

## Verification
The bench fires all eleven events at once with every enable off, to tell flag latching apart from request generation. It then arms all four vectors together and takes them one by one through accept and return pairs. This shows the priority order, the automatic clearing of the dedicated flags, and that the peripheral flags survive entry. The bench also collides an event with a software clear of the same flag. It holds the global disable bit while a source is enabled, to separate `wake` from `irq_req`. Each accepted vector goes into a scoreboard queue, and a monitor checks it at the handshake.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NDED = 3;
  localparam int NPER = 8;
  localparam int NSRC = NDED + NPER;
  localparam int NVEC = NDED + 1;
  localparam int CW   = NPER;
  localparam int AW   = 2;

  typedef enum logic [AW-1:0] {
    A_CORE  = 2'd0,
    A_PFLAG = 2'd1,
    A_PEN   = 2'd2,
    A_CTRL  = 2'd3
  } csr_addr_e;
endpackage

// File: rtl/vic_flags.sv
module vic_flags
  import vic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic [NDED-1:0] clr_ded,
  input  logic            set_gdis,
  input  logic            clr_gdis,
  input  logic            csr_we,
  input  logic [AW-1:0]   csr_addr,
  input  logic [CW-1:0]   csr_wdata,
  output logic [CW-1:0]   csr_rdata,
  output logic [NDED-1:0] ded_pend,
  output logic            per_pend,
  output logic            gdis
);
  localparam int EN_LSB = NDED + 1;

  logic [NDED-1:0] ded_flag, ded_en;
  logic [NPER-1:0] per_flag, per_en;
  logic            sum_en, gdis_q, per_sum;
  logic            wr_core, wr_pf, wr_pe, wr_ctrl;

  assign wr_core = csr_we && (csr_addr == A_CORE);
  assign wr_pf   = csr_we && (csr_addr == A_PFLAG);
  assign wr_pe   = csr_we && (csr_addr == A_PEN);
  assign wr_ctrl = csr_we && (csr_addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ded_flag <= '0;
      ded_en   <= '0;
      per_flag <= '0;
      per_en   <= '0;
      sum_en   <= 1'b0;
      gdis_q   <= 1'b1;
    end else begin
      ded_flag <= evt[NDED-1:0] |
                  (wr_core ? csr_wdata[NDED-1:0] : (ded_flag & ~clr_ded));
      per_flag <= evt[NSRC-1:NDED] | (wr_pf ? csr_wdata : per_flag);
      if (wr_core) begin
        ded_en <= csr_wdata[EN_LSB +: NDED];
        sum_en <= csr_wdata[CW-1];
      end
      if (wr_pe) per_en <= csr_wdata;
      if (set_gdis)      gdis_q <= 1'b1;
      else if (clr_gdis) gdis_q <= 1'b0;
      else if (wr_ctrl)  gdis_q <= csr_wdata[0];
    end
  end

  assign per_sum  = |(per_flag & per_en);
  assign per_pend = per_sum & sum_en;
  assign ded_pend = ded_flag & ded_en;
  assign gdis     = gdis_q;

  always_comb begin
    csr_rdata = '0;
    unique case (csr_addr)
      A_CORE:  csr_rdata = {sum_en, ded_en, per_sum, ded_flag};
      A_PFLAG: csr_rdata = per_flag;
      A_PEN:   csr_rdata = per_en;
      A_CTRL:  csr_rdata = {{(CW-1){1'b0}}, gdis_q};
      default: csr_rdata = '0;
    endcase
  end

  AST_HW_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> (({per_flag, ded_flag} & $past(evt)) == $past(evt))); // R2
  AST_GDIS_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    set_gdis |=> gdis_q); // R5
  AST_GDIS_OFF_RET: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_gdis && !set_gdis) |=> !gdis_q); // R7
  AST_PER_NO_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pf |=> ((per_flag & $past(per_flag)) == $past(per_flag))); // R6
endmodule

// File: rtl/vic_prio.sv
module vic_prio
  import vic_pkg::*;
#(
  parameter int           VW       = 16,
  parameter logic [VW-1:0] VEC_PIN  = 16'h0008,
  parameter logic [VW-1:0] VEC_TMR0 = 16'h0010,
  parameter logic [VW-1:0] VEC_TCLK = 16'h0018,
  parameter logic [VW-1:0] VEC_PERI = 16'h0020
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDED-1:0] ded_pend,
  input  logic            per_pend,
  input  logic            gdis,
  output logic            req,
  output logic [NVEC-1:0] sel,
  output logic [VW-1:0]   vec
);
  localparam logic [VW-1:0] VTAB [NVEC] = '{VEC_PIN, VEC_TMR0, VEC_TCLK, VEC_PERI};

  logic [NVEC-1:0] pend;
  assign pend = {per_pend, ded_pend};

  always_comb begin
    logic seen;
    seen = 1'b0;
    sel  = '0;
    for (int i = 0; i < NVEC; i++) begin
      sel[i] = pend[i] & ~seen;
      seen   = seen | pend[i];
    end
  end

  always_comb begin
    vec = '0;
    for (int i = 0; i < NVEC; i++)
      if (sel[i] && !gdis) vec = VTAB[i];
  end

  assign req = !gdis && (|pend);

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R4
  AST_REQ_HAS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (vec != '0)); // R4
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int           VW       = 16,
  parameter logic [VW-1:0] VEC_PIN  = 16'h0008,
  parameter logic [VW-1:0] VEC_TMR0 = 16'h0010,
  parameter logic [VW-1:0] VEC_TCLK = 16'h0018,
  parameter logic [VW-1:0] VEC_PERI = 16'h0020
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_evt,
  input  logic            csr_we,
  input  logic [AW-1:0]   csr_addr,
  input  logic [CW-1:0]   csr_wdata,
  output logic [CW-1:0]   csr_rdata,
  output logic            irq_req,
  input  logic            irq_ack,
  output logic [VW-1:0]   irq_vec,
  input  logic            irq_ret,
  output logic            stk_push,
  output logic            stk_pop,
  output logic            wake
);
  logic [NDED-1:0] ded_pend, clr_ded;
  logic            per_pend, gdis, accept;
  logic [NVEC-1:0] sel;

  assign accept  = irq_req & irq_ack;
  assign clr_ded = sel[NDED-1:0] & {NDED{accept}};

  vic_flags u_flags (
    .clk(clk), .rst_n(rst_n), .evt(src_evt), .clr_ded(clr_ded),
    .set_gdis(accept), .clr_gdis(irq_ret),
    .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .ded_pend(ded_pend), .per_pend(per_pend),
    .gdis(gdis)
  );

  vic_prio #(
    .VW(VW), .VEC_PIN(VEC_PIN), .VEC_TMR0(VEC_TMR0),
    .VEC_TCLK(VEC_TCLK), .VEC_PERI(VEC_PERI)
  ) u_prio (
    .clk(clk), .rst_n(rst_n), .ded_pend(ded_pend), .per_pend(per_pend),
    .gdis(gdis), .req(irq_req), .sel(sel), .vec(irq_vec)
  );

  assign stk_push = accept;
  assign stk_pop  = irq_ret;
  assign wake     = (|ded_pend) | per_pend;

  AST_ENTRY_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !irq_req); // R5
  AST_WAKE_COVERS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> wake); // R9

  for (genvar g = 0; g < NDED; g++) begin : g_autoclr
    AST_DED_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && sel[g] && !src_evt[g] && !(csr_we && csr_addr == A_CORE))
      |=> !ded_pend[g]); // R6
  end
endmodule

// File: tb/sim_vec_irq_ctrl.sv
`timescale 1ns/100ps
module sim_vec_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] src_evt = '0;
  logic        csr_we = 1'b0;
  logic [1:0]  csr_addr = '0;
  logic [7:0]  csr_wdata = '0;
  logic [7:0]  csr_rdata;
  logic        irq_req, irq_ack = 1'b0, irq_ret = 1'b0;
  logic [15:0] irq_vec;
  logic        stk_push, stk_pop, wake;

  int n_chk = 0, n_bad = 0;
  logic [15:0] exp_q [$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vec_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .irq_req(irq_req), .irq_ack(irq_ack), .irq_vec(irq_vec),
    .irq_ret(irq_ret), .stk_push(stk_push), .stk_pop(stk_pop), .wake(wake)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    csr_addr = a;
    #1 check(csr_rdata === exp, tag, csr_rdata, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_we = 1'b0;
  endtask

  task automatic pulse(input logic [10:0] v);
    @(negedge clk); src_evt = v;
    @(negedge clk); src_evt = '0;
  endtask

  task automatic take(input logic [15:0] v);
    @(negedge clk); exp_q.push_back(v); irq_ack = 1'b1;
    #1 check(stk_push === 1'b1, "R5 push on accept", stk_push, 1);
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic give_back();
    @(negedge clk); irq_ret = 1'b1;
    #1 check(stk_pop === 1'b1, "R7 pop on return", stk_pop, 1);
    @(negedge clk); irq_ret = 1'b0;
  endtask

  task automatic sig(input logic act, input logic exp, input string tag);
    #1 check(act === exp, tag, act, exp);
  endtask

  // scoreboard monitor: compares each accepted vector against the queue
  initial begin
    forever begin
      @(negedge clk); #1;
      if (irq_req && irq_ack) begin
        if (exp_q.size() == 0) check(1'b0, "R4 unexpected accept", irq_vec, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check(irq_vec === e, "R4 accepted vector", irq_vec, e);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(0, 8'h00, "R1 core word"); rd(1, 8'h00, "R1 peri flags");
    rd(2, 8'h00, "R1 peri enables"); rd(3, 8'h01, "R1 global disable");
    sig(irq_req, 1'b0, "R1 req"); sig(wake, 1'b0, "R1 wake");
    // R2 all events, nothing enabled
    pulse(11'h7FF);
    rd(0, 8'h07, "R2 dedicated flags"); rd(1, 8'hFF, "R2 peri flags");
    sig(wake, 1'b0, "R2 wake stays low"); sig(irq_req, 1'b0, "R2 req stays low");
    // R8 software clear and set
    wr(0, 8'h00); wr(1, 8'h00);
    rd(0, 8'h00, "R8 clear dedicated"); rd(1, 8'h00, "R8 clear peri");
    wr(1, 8'h82); rd(1, 8'h82, "R8 write one sets");
    @(negedge clk); src_evt = 11'h010; csr_we = 1'b1; csr_addr = 2'd1; csr_wdata = 8'h00;
    @(negedge clk); src_evt = '0; csr_we = 1'b0;
    rd(1, 8'h02, "R8 event beats clear");
    // R10 summary bit without its enable
    wr(2, 8'h02);
    rd(0, 8'h08, "R10 summary bit"); sig(wake, 1'b0, "R9 no wake without summary enable");
    wr(0, 8'h80);
    rd(0, 8'h88, "R10 summary with enable");
    sig(wake, 1'b1, "R9 wake while disabled"); sig(irq_req, 1'b0, "R3 blocked by global disable");
    wr(3, 8'h00);
    sig(irq_req, 1'b1, "R3 req after enable");
    check(irq_vec === 16'h0020, "R4 peripheral vector", irq_vec, 16'h0020);
    // arm all four vectors
    wr(0, 8'hF7);
    rd(0, 8'hFF, "R8 core word armed");
    check(irq_vec === 16'h0008, "R4 pin first", irq_vec, 16'h0008);
    take(16'h0008);
    sig(irq_req, 1'b0, "R5 req low after entry");
    rd(3, 8'h01, "R5 global disable set"); rd(0, 8'hFE, "R6 pin flag cleared");
    give_back();
    sig(irq_req, 1'b1, "R7 req back after return");
    check(irq_vec === 16'h0010, "R4 timer-0 next", irq_vec, 16'h0010);
    take(16'h0010); rd(0, 8'hFC, "R6 timer-0 flag cleared");
    give_back();
    #1 check(irq_vec === 16'h0018, "R4 clock edge next", irq_vec, 16'h0018);
    take(16'h0018); rd(0, 8'hF8, "R6 clock-edge flag cleared");
    give_back();
    #1 check(irq_vec === 16'h0020, "R4 peripheral last", irq_vec, 16'h0020);
    take(16'h0020);
    rd(1, 8'h02, "R6 peri flags kept"); rd(0, 8'hF8, "R6 summary still set");
    give_back();
    sig(irq_req, 1'b1, "R6 peri request persists");
    wr(1, 8'h00);
    sig(irq_req, 1'b0, "R3 req low after sw clear"); sig(wake, 1'b0, "R9 wake low");
    // R2 fresh enabled event
    pulse(11'h002);
    sig(irq_req, 1'b1, "R2 timer-0 event raises req");
    check(irq_vec === 16'h0010, "R4 timer-0 alone", irq_vec, 16'h0010);
    take(16'h0010);
    @(negedge clk);
    check(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule